// File: doc/BRIEF.md
# Next-PC and Branch Resolution Unit

This unit owns the program counter of a single-cycle 32-bit integer core. Each cycle the decoder presents one-hot style control-flow flags for the six conditional branches and the two jumps. It also presents the two source register values and the sign-extended immediate. The unit resolves the branch condition, forms both jump targets, and registers the program counter for the next cycle.

The current PC drives instruction fetch. The unit also reports whether a conditional branch was taken, and it gives the return address that a jump writes to its link register. Register-relative jumps have bit 0 of their target forced low. When no control-flow flag is active the PC advances by one 4-byte instruction.

Top module: `cf_pc_unit`

## Requirements
- R1: While rst_ni is low the PC output is 0, and asserting rst_ni low forces the PC to 0 at once, without waiting for a clock edge.
- R2: With no branch taken and neither jump flag set, the PC on the next rising edge is the current PC plus 4.
- R3: When br_taken_o is high, the next PC is the current PC plus imm_i.
- R4: When jal_i is high and no branch is taken, the next PC is the current PC plus imm_i.
- R5: When jalr_i is high, jal_i is low and no branch is taken, the next PC is rs1_val_i plus imm_i with bit 0 cleared.
- R6: The target is chosen by priority: first a taken branch, then jal_i, then jalr_i, and otherwise PC plus 4.
- R7: beq_i is taken when the operands are equal and bne_i when they differ. blt_i and bge_i compare the operands as two's-complement numbers (less, greater-or-equal). bltu_i and bgeu_i compare them unsigned.
- R8: br_taken_o is high only when exactly one of the six branch flags is set and its condition holds. It is low when no branch flag is set or when two or more are set.
- R9: link_vld_o equals jal_i OR jalr_i, and whenever it is high link_o equals the current PC plus 4.
- R10: pc_o shows the registered PC. A jal with a zero immediate holds the PC at the same address cycle after cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock, rising edge |
| rst_ni | input | 1 | Asynchronous reset, active low |
| beq_i | input | 1 | Branch if equal |
| bne_i | input | 1 | Branch if not equal |
| blt_i | input | 1 | Branch if less, signed |
| bge_i | input | 1 | Branch if greater or equal, signed |
| bltu_i | input | 1 | Branch if less, unsigned |
| bgeu_i | input | 1 | Branch if greater or equal, unsigned |
| jal_i | input | 1 | PC-relative jump |
| jalr_i | input | 1 | Register-relative jump |
| rs1_val_i | input | 32 | First source operand |
| rs2_val_i | input | 32 | Second source operand |
| imm_i | input | 32 | Sign-extended immediate |
| pc_o | output | 32 | Current program counter |
| br_taken_o | output | 1 | Conditional branch taken this cycle |
| link_o | output | 32 | Return address, PC plus 4 |
| link_vld_o | output | 1 | link_o is meaningful (jump active) |

## Verification
The hardest cases to reach are the ones where the priority select must break a conflict. Examples are a taken branch together with a register jump, or two branch flags at once. A well-formed instruction stream never produces them, so the bench drives these flag combinations directly, alongside a summing loop that runs as an ordinary program. The bench picks operand pairs whose signed and unsigned orderings disagree (all-ones against one), and equal pairs, so each condition is seen both taken and not taken. The loop checks the exit iteration through the count of taken branches, and a self-jump at the end checks that the PC holds.

// File: rtl/cf_pkg.sv
package cf_pkg;
  typedef struct packed {
    logic bgeu;
    logic bltu;
    logic bge;
    logic blt;
    logic bne;
    logic beq;
  } br_flags_t;

  localparam int unsigned NUM_BR = 6;

  typedef enum logic [1:0] {
    SEL_SEQ  = 2'd0,
    SEL_BR   = 2'd1,
    SEL_JAL  = 2'd2,
    SEL_JALR = 2'd3
  } pc_sel_e;
endpackage

// File: rtl/cf_cond_eval.sv
module cf_cond_eval
  import cf_pkg::*;
#(
  parameter int unsigned XLEN = 32
) (
  input  br_flags_t        flags_i,
  input  logic [XLEN-1:0]  op_a_i,
  input  logic [XLEN-1:0]  op_b_i,
  output logic             taken_o
);
  logic [NUM_BR-1:0] flag_vec;
  logic [NUM_BR-1:0] cond_vec;
  logic              eq, lt_s, lt_u, single;

  assign flag_vec = flags_i;
  assign eq   = (op_a_i == op_b_i);
  assign lt_s = ($signed(op_a_i) < $signed(op_b_i));
  assign lt_u = (op_a_i < op_b_i);

  // bit order follows br_flags_t: beq, bne, blt, bge, bltu, bgeu
  assign cond_vec = {~lt_u, lt_u, ~lt_s, lt_s, ~eq, eq};

  // exactly one flag: non-zero and clearing the lowest set bit leaves nothing
  assign single  = (flag_vec != '0) && ((flag_vec & (flag_vec - 1'b1)) == '0);
  assign taken_o = single && |(flag_vec & cond_vec);
endmodule

// File: rtl/cf_target_gen.sv
module cf_target_gen #(
  parameter int unsigned XLEN        = 32,
  parameter int unsigned INSTR_BYTES = 4
) (
  input  logic [XLEN-1:0] pc_i,
  input  logic [XLEN-1:0] rs1_i,
  input  logic [XLEN-1:0] imm_i,
  output logic [XLEN-1:0] seq_pc_o,
  output logic [XLEN-1:0] rel_tgt_o,
  output logic [XLEN-1:0] reg_tgt_o
);
  localparam logic [XLEN-1:0] STEP    = XLEN'(INSTR_BYTES);
  localparam logic [XLEN-1:0] LSB_CLR = ~XLEN'(1);

  logic [XLEN-1:0] reg_sum;

  // two independent adders so the PC-relative and register-relative paths run in parallel
  assign seq_pc_o  = pc_i + STEP;
  assign rel_tgt_o = pc_i + imm_i;
  assign reg_sum   = rs1_i + imm_i;
  assign reg_tgt_o = reg_sum & LSB_CLR;
endmodule

// File: rtl/cf_pc_reg.sv
module cf_pc_reg
  import cf_pkg::*;
#(
  parameter int unsigned     XLEN     = 32,
  parameter logic [XLEN-1:0] RESET_PC = '0
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  pc_sel_e         sel_i,
  input  logic [XLEN-1:0] seq_pc_i,
  input  logic [XLEN-1:0] rel_tgt_i,
  input  logic [XLEN-1:0] reg_tgt_i,
  output logic [XLEN-1:0] pc_o
);
  logic [XLEN-1:0] pc_d, pc_q;

  always_comb begin
    unique case (sel_i)
      SEL_BR, SEL_JAL: pc_d = rel_tgt_i;
      SEL_JALR:        pc_d = reg_tgt_i;
      default:         pc_d = seq_pc_i;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) pc_q <= RESET_PC;
    else         pc_q <= pc_d;
  end

  assign pc_o = pc_q;
endmodule

// File: rtl/cf_pc_unit.sv
module cf_pc_unit
  import cf_pkg::*;
#(
  parameter int unsigned     XLEN        = 32,
  parameter int unsigned     INSTR_BYTES = 4,
  parameter logic [XLEN-1:0] RESET_PC    = '0
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            beq_i,
  input  logic            bne_i,
  input  logic            blt_i,
  input  logic            bge_i,
  input  logic            bltu_i,
  input  logic            bgeu_i,
  input  logic            jal_i,
  input  logic            jalr_i,
  input  logic [XLEN-1:0] rs1_val_i,
  input  logic [XLEN-1:0] rs2_val_i,
  input  logic [XLEN-1:0] imm_i,
  output logic [XLEN-1:0] pc_o,
  output logic            br_taken_o,
  output logic [XLEN-1:0] link_o,
  output logic            link_vld_o
);
  br_flags_t       flags;
  logic            taken;
  logic [XLEN-1:0] pc_q, seq_pc, rel_tgt, reg_tgt;
  pc_sel_e         sel;

  assign flags = '{bgeu: bgeu_i, bltu: bltu_i, bge: bge_i, blt: blt_i,
                   bne: bne_i, beq: beq_i};

  cf_cond_eval #(.XLEN(XLEN)) i_cond (
    .flags_i (flags),
    .op_a_i  (rs1_val_i),
    .op_b_i  (rs2_val_i),
    .taken_o (taken)
  );

  cf_target_gen #(.XLEN(XLEN), .INSTR_BYTES(INSTR_BYTES)) i_tgt (
    .pc_i      (pc_q),
    .rs1_i     (rs1_val_i),
    .imm_i     (imm_i),
    .seq_pc_o  (seq_pc),
    .rel_tgt_o (rel_tgt),
    .reg_tgt_o (reg_tgt)
  );

  // priority: taken branch, then jal, then jalr
  always_comb begin
    if (taken)       sel = SEL_BR;
    else if (jal_i)  sel = SEL_JAL;
    else if (jalr_i) sel = SEL_JALR;
    else             sel = SEL_SEQ;
  end

  cf_pc_reg #(.XLEN(XLEN), .RESET_PC(RESET_PC)) i_pc (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .sel_i     (sel),
    .seq_pc_i  (seq_pc),
    .rel_tgt_i (rel_tgt),
    .reg_tgt_i (reg_tgt),
    .pc_o      (pc_q)
  );

  assign pc_o       = pc_q;
  assign br_taken_o = taken;
  assign link_o     = seq_pc;
  assign link_vld_o = jal_i | jalr_i;
endmodule

// File: rtl/cf_pc_unit_chk.sv
module cf_pc_unit_chk #(
  parameter int unsigned     XLEN        = 32,
  parameter int unsigned     INSTR_BYTES = 4,
  parameter logic [XLEN-1:0] RESET_PC    = '0
) (
  input logic            clk_i,
  input logic            rst_ni,
  input logic            beq_i,
  input logic            bne_i,
  input logic            blt_i,
  input logic            bge_i,
  input logic            bltu_i,
  input logic            bgeu_i,
  input logic            jal_i,
  input logic            jalr_i,
  input logic [XLEN-1:0] rs1_val_i,
  input logic [XLEN-1:0] imm_i,
  input logic [XLEN-1:0] pc_o,
  input logic            br_taken_o,
  input logic [XLEN-1:0] link_o,
  input logic            link_vld_o
);
  localparam logic [XLEN-1:0] STEP = XLEN'(INSTR_BYTES);

  logic [5:0] br_vec;
  assign br_vec = {bgeu_i, bltu_i, bge_i, blt_i, bne_i, beq_i};

  // R1
  reset_pc_chk: assert property (@(posedge clk_i) !rst_ni |-> pc_o == RESET_PC);

  // R2
  seq_step_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!br_taken_o && !jal_i && !jalr_i) |=> pc_o == $past(pc_o) + STEP);

  // R3
  br_target_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    br_taken_o |=> pc_o == $past(pc_o) + $past(imm_i));

  // R4
  jal_target_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (jal_i && !br_taken_o) |=> pc_o == $past(pc_o) + $past(imm_i));

  // R5
  jalr_target_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (jalr_i && !jal_i && !br_taken_o) |=>
      pc_o == (($past(rs1_val_i) + $past(imm_i)) & ~XLEN'(1)));

  // R8
  single_flag_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    br_taken_o |-> $countones(br_vec) == 1);

  // R9
  link_val_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    link_vld_o |-> link_o == pc_o + STEP);
endmodule

bind cf_pc_unit cf_pc_unit_chk #(
  .XLEN(XLEN), .INSTR_BYTES(INSTR_BYTES), .RESET_PC(RESET_PC)
) i_cf_pc_unit_chk (
  .clk_i(clk_i), .rst_ni(rst_ni),
  .beq_i(beq_i), .bne_i(bne_i), .blt_i(blt_i), .bge_i(bge_i),
  .bltu_i(bltu_i), .bgeu_i(bgeu_i), .jal_i(jal_i), .jalr_i(jalr_i),
  .rs1_val_i(rs1_val_i), .imm_i(imm_i), .pc_o(pc_o),
  .br_taken_o(br_taken_o), .link_o(link_o), .link_vld_o(link_vld_o)
);

// File: tb/test_cf_pc_unit.sv
module test_cf_pc_unit;
  localparam int unsigned CYC = 10;

  // flag vector bit positions used by the bench only
  localparam logic [7:0] F_BEQ = 8'h01, F_BNE = 8'h02, F_BLT = 8'h04, F_BGE = 8'h08,
                         F_BLTU = 8'h10, F_BGEU = 8'h20, F_JAL = 8'h40, F_JALR = 8'h80;

  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b1;
  logic [7:0]  fl = '0;
  logic [31:0] rs1 = '0, rs2 = '0, imm = '0;
  logic [31:0] pc_o, link_o;
  logic        br_taken_o, link_vld_o;

  always #(CYC/2) clk_i = ~clk_i;

  cf_pc_unit i_cf_pc_unit (
    .clk_i(clk_i), .rst_ni(rst_ni),
    .beq_i(fl[0]), .bne_i(fl[1]), .blt_i(fl[2]), .bge_i(fl[3]),
    .bltu_i(fl[4]), .bgeu_i(fl[5]), .jal_i(fl[6]), .jalr_i(fl[7]),
    .rs1_val_i(rs1), .rs2_val_i(rs2), .imm_i(imm),
    .pc_o(pc_o), .br_taken_o(br_taken_o), .link_o(link_o), .link_vld_o(link_vld_o)
  );

  typedef struct {
    logic [31:0] pc;
    logic        taken;
    logic        lvld;
    string       tag;
  } exp_t;

  exp_t        sb_q[$];
  int          checks = 0, errors = 0;
  logic [31:0] pc_m = '0;
  int          taken_cnt = 0;
  logic        count_en = 1'b0;

  function automatic void check(string tag, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual 0x%08h expected 0x%08h", tag, act, exp);
    end
  endfunction

  // driver: apply one cycle of flags and operands, push the expected outcome
  task automatic step(input logic [7:0] f, input logic [31:0] a, input logic [31:0] b,
                      input logic [31:0] im, input string tag);
    logic [5:0] cond;
    logic       tk;
    @(negedge clk_i);
    #1;
    fl = f; rs1 = a; rs2 = b; imm = im;
    cond = {a >= b, a < b, $signed(a) >= $signed(b), $signed(a) < $signed(b), a != b, a == b};
    tk = ($countones(f[5:0]) == 1) && |(f[5:0] & cond);
    sb_q.push_back('{pc: pc_m, taken: tk, lvld: f[6] | f[7], tag: tag});
    if (tk || f[6]) pc_m = pc_m + im;
    else if (f[7])  pc_m = (a + im) & 32'hFFFF_FFFE;
    else            pc_m = pc_m + 32'd4;
  endtask

  // monitor: late in the low phase, compare against the queued item
  initial begin
    exp_t it;
    forever begin
      @(negedge clk_i);
      #3;
      if (sb_q.size() > 0) begin
        it = sb_q.pop_front();
        check({it.tag, " R10 pc"}, pc_o, it.pc);
        check({it.tag, " R8 taken"}, 32'(br_taken_o), 32'(it.taken));
        check({it.tag, " R9 link_vld"}, 32'(link_vld_o), 32'(it.lvld));
        if (it.lvld) check({it.tag, " R9 link"}, link_o, it.pc + 32'd4);
        if (count_en && br_taken_o) taken_cnt++;
      end
    end
  end

  initial begin
    #(CYC * 200000);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    int x[32];
    int body = 0;
    for (int i = 0; i < 32; i++) x[i] = 0;

    #1 rst_ni = 1'b0;
    #2 check("R1 async reset", pc_o, 32'd0);
    repeat (2) @(posedge clk_i);
    #1 rst_ni = 1'b1;

    // summing loop; bench decodes by its own PC model
    count_en = 1'b1;
    for (int n = 0; n < 100 && pc_m != 32'd28; n++) begin
      case (pc_m)
        32'd0:  begin x[14] = 0;  step(8'h00, 0, 0, 0, "R2 init"); end
        32'd4:  begin x[12] = 10; step(8'h00, 0, 0, 10, "R2 init"); end
        32'd8:  begin x[13] = 1;  step(8'h00, 0, 0, 1, "R2 init"); end
        32'd12: begin x[14] += x[13]; body++; step(8'h00, 32'(x[14]), 32'(x[13]), 0, "R2 body"); end
        32'd16: begin x[13] += 1; step(8'h00, 32'(x[13]), 0, 1, "R2 body"); end
        32'd20: step(F_BLT, 32'(x[13]), 32'(x[12]), -32'sd8, "R3 loop blt");
        32'd24: begin x[30] = (x[14] == 45) ? 1 : 0; step(8'h00, 0, 0, 0, "R2 check"); end
        default: step(8'h00, 0, 0, 0, "R2 stray");
      endcase
    end
    repeat (4) step(F_JAL, 0, 0, 0, "R10 self jump");
    repeat (2) @(negedge clk_i);
    count_en = 1'b0;
    check("R3 loop taken count", 32'(taken_cnt), 32'd8);
    check("R7 loop sum", 32'(x[14]), 32'd45);
    check("R10 body iterations", 32'(body), 32'd9);

    // R5 register jump with odd target
    step(F_JALR, 32'h101, 0, 32'h10, "R5 jalr lsb");
    step(8'h00, 0, 0, 0, "R2 seq");
    // R7 conditions
    step(F_BEQ,  32'd5, 32'd5, 32'h40, "R7 beq eq");
    step(F_BNE,  32'd5, 32'd5, 32'h40, "R7 bne eq");
    step(F_BNE,  32'd5, 32'd6, 32'h40, "R7 bne ne");
    step(F_BEQ,  32'd5, 32'd6, 32'h40, "R7 beq ne");
    step(F_BLT,  32'hFFFF_FFFF, 32'd1, -32'sd32, "R7 blt signed");
    step(F_BLTU, 32'hFFFF_FFFF, 32'd1, 32'h80, "R7 bltu unsigned");
    step(F_BGE,  32'hFFFF_FFFF, 32'd1, 32'h80, "R7 bge signed");
    step(F_BGEU, 32'hFFFF_FFFF, 32'd1, 32'h80, "R7 bgeu unsigned");
    step(F_BGE,  32'd7, 32'd7, 32'h20, "R7 bge equal");
    step(F_BLTU, 32'd1, 32'hFFFF_FFFF, 32'h20, "R7 bltu small");
    step(F_BLT,  32'h8000_0000, 32'h7FFF_FFFF, 32'h20, "R7 blt min");
    // R8 multiple flags
    step(F_BEQ | F_BGE, 32'd3, 32'd3, 32'h100, "R8 two flags");
    step(F_BEQ | F_BNE | F_BLTU, 32'd3, 32'd4, 32'h100, "R8 three flags");
    // R6 priority
    step(F_BEQ | F_JALR, 32'd9, 32'd9, 32'h18, "R6 br over jalr");
    step(F_BNE | F_JALR, 32'h2000, 32'h2000, 32'h8, "R6 jalr when br not taken");
    step(F_JAL | F_JALR, 32'h4000, 0, 32'h30, "R6 jal over jalr");
    step(F_BLT | F_JAL, 32'd9, 32'd1, -32'sd16, "R4 jal when br not taken");
    step(F_BEQ | F_JAL, 32'd2, 32'd2, 32'h44, "R6 br with jal");
    step(F_JALR, 32'h3000, 0, -32'sd1, "R5 jalr neg imm");
    repeat (2) @(negedge clk_i);

    // R1 reset mid-run
    #1 rst_ni = 1'b0;
    #1 check("R1 reset mid-run", pc_o, 32'd0);
    @(posedge clk_i);
    #1 check("R1 held in reset", pc_o, 32'd0);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule